// File: doc/BRIEF.md
# Seconds countdown timer

This peripheral sits on a narrow 8-bit I/O bus and measures out whole seconds for a polling processor. A prescaler divides the system clock, 50 MHz by default, down to one single-cycle tick per second. A down-counter spends one tick per loaded unit.

Software writes a number of seconds to the load register, which starts the countdown at once. It then reads the status register in a loop until the busy flag drops. The block is addressed through a two-bit register select. The decode of the wider bus address into that select lies outside the block.

A new load while the timer is running replaces the remaining count and restarts the one-second phase from zero. A load of zero stops the timer.

Top module: `sec_timer_top`

## Requirements
- R1: A write with `reg_sel` = 2 and a nonzero `wr_data` sets the busy flag from the next clock cycle on.
- R2: After such a write of value N (1 to 255), the busy flag stays set for exactly N × PRESCALE clock cycles, where PRESCALE = CLK_HZ / TICK_HZ (50,000,000 by default). The remaining count drops by one once per PRESCALE cycles.
- R3: The busy flag clears when the remaining count reaches zero, and the busy flag is never set while the count is zero.
- R4: A nonzero write at offset 2 while busy reloads the count and restarts the prescaler phase from zero. The total busy time then equals the cycles up to the reload plus the new value × PRESCALE.
- R5: A write of zero at offset 2 leaves the busy flag clear, both when the timer is idle and when it is running.
- R6: A read with `rd_en` high and `reg_sel` = 0 returns status: bit 0 is the busy flag and bits 7 to 1 read as zero.
- R7: A read at offsets 1, 2 or 3, or any cycle with `rd_en` low, returns 0x00.
- R8: Writes at offsets 0, 1 and 3 have no effect: they do not start the timer and do not change the remaining count.
- R9: A synchronous reset clears the busy flag and the count, and restarts the prescaler phase.
- R10: Without a load write, an idle timer stays idle and the prescaler produces no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register offset within the four-address window |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data (seconds count at offset 2) |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data; status at offset 0, zero elsewhere |

## Verification
Durations of one, three and 255 seconds show that each unit costs a full prescaler period, and that the count is decoded over its whole width with no wrap or truncation. A reload in mid-run separates a restarted phase from one that carries on, because the total busy time differs by the prescaler phase that was thrown away.

Zero loads, both idle and running, test the guard on the busy flag. Writes at the other offsets test the offset decode. Reads of every offset while busy and while idle test the read mux and the zero upper status bits. A reset in mid-run shows that the busy flag drops at once and stays low.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;

   // register offsets inside the four-address window
   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      OFS_STATUS = 2'd0,
      OFS_SPARE1 = 2'd1,
      OFS_LOAD   = 2'd2,
      OFS_SPARE3 = 2'd3
   } tmr_ofs_e;

   localparam int unsigned DEF_CLK_HZ  = 50_000_000;
   localparam int unsigned DEF_TICK_HZ = 1;
   localparam int unsigned DEF_DATA_W  = 8;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sec_tick_gen.sv
module sec_tick_gen #(
   parameter int unsigned PRESCALE = 50_000_000
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic run,
   output logic tick
);
   import sec_timer_pkg::*;

   localparam int unsigned CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

   if (PRESCALE < 2) begin : g_bad_prescale
      $error("sec_tick_gen: PRESCALE must be at least 2");
   end

   logic [CNT_W-1:0] phase_q;

   if (is_pow2(PRESCALE)) begin : g_wrap
      // power of two: natural wrap, no terminal compare on the reload path
      always_ff @(posedge clk) begin
         if (rst || restart || !run) phase_q <= '0;
         else                        phase_q <= phase_q + 1'b1;
      end
   end else begin : g_cmp
      always_ff @(posedge clk) begin
         if (rst || restart || !run) phase_q <= '0;
         else if (phase_q == LAST)   phase_q <= '0;
         else                        phase_q <= phase_q + 1'b1;
      end
   end

   assign tick = run && !restart && (phase_q == LAST);

   // R2: ticks are at least a prescaler period apart, never back to back
   a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // R4: a restart leaves a fresh phase, so no tick in the next cycle
   a_r4_restart_phase: assert property (@(posedge clk) disable iff (rst)
      restart |=> !tick);

endmodule

// File: rtl/sec_countdown.sv
module sec_countdown #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              tick,
   output logic              busy,
   output logic [DATA_W-1:0] remain
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   if (DATA_W < 1) begin : g_bad_width
      $error("sec_countdown: DATA_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         remain <= '0;
         busy   <= 1'b0;
      end else if (load) begin
         remain <= load_val;
         busy   <= (load_val != '0);
      end else if (busy && tick) begin
         remain <= remain - ONE;
         if (remain == ONE) busy <= 1'b0;
      end
   end

   // R3: busy flag and nonzero count travel together
   a_r3_busy_count: assert property (@(posedge clk) disable iff (rst)
      busy |-> (remain != '0));

   // R2: the count only moves on a tick or a load
   a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
      (!load && !tick) |=> $stable(remain));

   // R2: a tick while busy takes exactly one unit off
   a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
      (!load && tick && busy) |=> (remain == $past(remain) - ONE));

   // R9: reset leaves the counter empty and idle
   a_r9_reset_clear: assert property (@(posedge clk)
      rst |=> (!busy && remain == '0));

endmodule

// File: rtl/sec_timer_regs.sv
module sec_timer_regs #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned BUSY_BIT = 0
) (
   input  logic                               reg_sel_in,
   input  logic [sec_timer_pkg::SEL_W-1:0]    reg_sel,
   input  logic                               wr_en,
   input  logic [DATA_W-1:0]                  wr_data,
   input  logic                               rd_en,
   input  logic                               busy,
   output logic                               load,
   output logic [DATA_W-1:0]                  load_val,
   output logic [DATA_W-1:0]                  rd_data
);
   import sec_timer_pkg::*;

   if (BUSY_BIT >= DATA_W) begin : g_bad_bit
      $error("sec_timer_regs: BUSY_BIT outside the data width");
   end

   tmr_ofs_e ofs;
   assign ofs = tmr_ofs_e'(reg_sel);

   assign load     = wr_en && reg_sel_in && (ofs == OFS_LOAD);
   assign load_val = wr_data;

   always_comb begin
      rd_data = '0;
      if (rd_en && (ofs == OFS_STATUS)) rd_data[BUSY_BIT] = busy;
   end

endmodule

// File: rtl/sec_timer_top.sv
module sec_timer_top #(
   parameter int unsigned CLK_HZ  = sec_timer_pkg::DEF_CLK_HZ,
   parameter int unsigned TICK_HZ = sec_timer_pkg::DEF_TICK_HZ,
   parameter int unsigned DATA_W  = sec_timer_pkg::DEF_DATA_W
) (
   input  logic        clk,
   input  logic        rst,
   input  logic [1:0]  reg_sel,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   input  logic        rd_en,
   output logic [7:0]  rd_data
);
   import sec_timer_pkg::*;

   localparam int unsigned PRESCALE = CLK_HZ / TICK_HZ;

   if (TICK_HZ == 0 || CLK_HZ < 2 * TICK_HZ) begin : g_bad_rate
      $error("sec_timer_top: clock must be at least twice the tick rate");
   end
   if (DATA_W != 8) begin : g_bad_bus
      $error("sec_timer_top: the bus ports are 8 bits wide");
   end

   logic              load;
   logic [DATA_W-1:0] load_val;
   logic              tick;
   logic              busy;
   logic [DATA_W-1:0] remain;

   sec_timer_regs #(
      .DATA_W   (DATA_W),
      .BUSY_BIT (0)
   ) i_regs (
      .reg_sel_in (1'b1),
      .reg_sel    (reg_sel),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .rd_en      (rd_en),
      .busy       (busy),
      .load       (load),
      .load_val   (load_val),
      .rd_data    (rd_data)
   );

   sec_tick_gen #(
      .PRESCALE (PRESCALE)
   ) i_tick (
      .clk     (clk),
      .rst     (rst),
      .restart (load),
      .run     (busy),
      .tick    (tick)
   );

   sec_countdown #(
      .DATA_W (DATA_W)
   ) i_count (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (load_val),
      .tick     (tick),
      .busy     (busy),
      .remain   (remain)
   );

   // R1: nonzero load starts the timer
   a_r1_start: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_sel == OFS_LOAD && wr_data != '0) |=> busy);

   // R5: zero load leaves the timer idle
   a_r5_zero_load: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_sel == OFS_LOAD && wr_data == '0) |=> !busy);

   // R6: status read shows the busy flag in bit 0, zeros above
   a_r6_status_fmt: assert property (@(posedge clk) disable iff (rst)
      (rd_en && reg_sel == OFS_STATUS) |-> (rd_data == {7'd0, busy}));

   // R7: other offsets and idle strobe read zero
   a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
      (!rd_en || reg_sel != OFS_STATUS) |-> (rd_data == 8'h00));

   // R8: writes elsewhere leave the count alone
   a_r8_other_write: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_sel != OFS_LOAD && !tick) |=> $stable(remain));

   // R10: idle stays idle without a load, and no tick while idle
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!busy && !load) |=> !busy);
   a_r10_no_idle_tick: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !tick);

endmodule

// File: tb/test_sec_timer_top.sv
module test_sec_timer_top;

   localparam int P        = 10;      // prescaler used by the bench
   localparam int WD_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst;
   logic [1:0] reg_sel;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       rd_en;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int exp_q[$];
   bit running = 1'b0;
   int start_cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sec_timer_top #(
      .CLK_HZ  (P),
      .TICK_HZ (1),
      .DATA_W  (8)
   ) i_sec_timer_top (
      .clk     (clk),
      .rst     (rst),
      .reg_sel (reg_sel),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // read one offset inside a single negedge slot, then return to status
   task automatic rd(input logic [1:0] s, output logic [7:0] v);
      @(negedge clk);
      reg_sel = s;
      rd_en   = 1'b1;
      #1 v = rd_data;
      reg_sel = 2'd0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; reg_sel = 2'd0; wr_data = 8'h00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      idle(2);
   endtask

   // monitor: times busy from the load edge to the first idle status sample
   always @(posedge clk) begin
      cyc++;
      if (rst) running = 1'b0;
      else if (wr_en && reg_sel == 2'd2) begin
         if (wr_data != 8'h00 && !running) begin
            running   = 1'b1;
            start_cyc = cyc;
         end else if (wr_data == 8'h00) running = 1'b0;
      end
      #1;
      if (running && rd_en && reg_sel == 2'd0 && rd_data[0] == 1'b0) begin
         running = 1'b0;
         if (exp_q.size() == 0) check("R2 unexpected completion", cyc - start_cyc, -1);
         else check("R2/R4 busy duration", cyc - start_cyc, exp_q.pop_front());
      end
   end

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      rst = 1'b1; reg_sel = 2'd0; wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b1;
      idle(3);
      rst = 1'b0;

      // R9 reset state, R7 unused offsets idle
      rd(2'd0, v); check("R9 status after reset", v, 8'h00);
      for (int o = 1; o < 4; o++) begin
         rd(o[1:0], v); check("R7 idle offset read", v, 8'h00);
      end
      // R7 strobe low reads zero
      @(negedge clk); rd_en = 1'b0; #1 check("R7 rd_en low", rd_data, 8'h00); rd_en = 1'b1;

      // R1/R2 one second
      exp_q.push_back(1 * P);
      wr(2'd2, 8'd1);
      drain();

      // R2 three seconds, R6 status format and R7 offsets while busy
      exp_q.push_back(3 * P);
      wr(2'd2, 8'd3);
      rd(2'd0, v); check("R6 status while busy", v, 8'h01);
      rd(2'd1, v); check("R7 offset 1 while busy", v, 8'h00);
      rd(2'd2, v); check("R7 offset 2 while busy", v, 8'h00);
      rd(2'd3, v); check("R7 offset 3 while busy", v, 8'h00);
      drain();
      rd(2'd0, v); check("R3 status after finish", v, 8'h00);

      // R10 idle stays idle
      idle(3 * P);
      rd(2'd0, v); check("R10 idle hold", v, 8'h00);

      // R2 full range
      exp_q.push_back(255 * P);
      wr(2'd2, 8'd255);
      drain();

      // R4 reload mid-run: write 4, wait 17 cycles, write 2 -> (17+2) + 2*P
      exp_q.push_back(17 + 2 + 2 * P);
      wr(2'd2, 8'd4);
      idle(17);
      wr(2'd2, 8'd2);
      drain();

      // R5 zero load while idle
      wr(2'd2, 8'd0);
      rd(2'd0, v); check("R5 zero load idle", v, 8'h00);

      // R5 zero load while running
      wr(2'd2, 8'd5);
      idle(4);
      rd(2'd0, v); check("R1 busy before zero load", v, 8'h01);
      wr(2'd2, 8'd0);
      rd(2'd0, v); check("R5 zero load stops run", v, 8'h00);
      idle(6 * P);
      rd(2'd0, v); check("R5 stays stopped", v, 8'h00);

      // R8 writes at other offsets ignored
      wr(2'd0, 8'd5);
      wr(2'd1, 8'd7);
      wr(2'd3, 8'd9);
      rd(2'd0, v); check("R8 other offsets no start", v, 8'h00);
      // R8 while running: count unchanged -> duration unaffected
      exp_q.push_back(2 * P);
      wr(2'd2, 8'd2);
      wr(2'd3, 8'd200);
      wr(2'd0, 8'd200);
      drain();

      // R9 reset mid-run
      wr(2'd2, 8'd9);
      idle(5);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      rd(2'd0, v); check("R9 reset mid-run", v, 8'h00);
      idle(10 * P);
      rd(2'd0, v); check("R9 stays idle after reset", v, 8'h00);

      // R2 after reset the timer still times correctly
      exp_q.push_back(1 * P);
      wr(2'd2, 8'd1);
      drain();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule